// File: doc/BRIEF.md
# Prefixed Compact Instruction Decoder

This block sits between instruction fetch and issue in a processor whose instructions are 16 bits wide. Each 32-bit fetch word holds two instructions. The decoder holds one fetch word, issues its lower half and then its upper half, and asks for the next word only when the upper half is leaving. For every issued instruction it gives a one-hot class, an operation field, up to two register indices and a resolved 16-bit immediate. Downstream accepts an instruction with a valid/ready handshake.

A prefix instruction is never issued downstream. It is absorbed into a pending-prefix register, which takes one slot cycle whether or not downstream is ready. The next non-prefix instruction of any class consumes that register and clears it. For short immediates and offsets, the 12-bit prefix is placed above the 4-bit field. A flush input drops the held fetch word and the pending prefix.

Two small state machines control the block. The unpacker has the states U_EMPTY, U_LOW and U_HIGH, with these transitions: U_EMPTY to U_LOW when a word is accepted; U_LOW to U_HIGH when the lower slot advances; U_HIGH to U_LOW when the upper slot advances and a new word is accepted in the same cycle; U_HIGH to U_EMPTY when the upper slot advances and no word arrives; and any state to U_EMPTY on flush. The prefix tracker has the states P_IDLE and P_HELD, with these transitions: P_IDLE or P_HELD to P_HELD when a prefix slot advances (the latest value is loaded); P_HELD to P_IDLE when a non-prefix slot advances; and any state to P_IDLE on flush.

Top module: `dualop_decoder`

## Requirements
- R1: After reset, fw_ready is 1, ins_valid is 0 and no prefix is pending.
- R2: The instruction in fw_data[15:0] issues before the one in fw_data[31:16]. A word is accepted (fw_valid and fw_ready both high at a clock edge) only when the decoder is empty, or in the same cycle as the upper half advances. The first half is presented in the cycle after acceptance.
- R3: The class comes from the top bits of the instruction. 00 is arithmetic (ins_class bit 0), 01 is conditional test (bit 1), 100 is load (bit 2), 101 is store (bit 3), 1100 is coprocessor load (bit 4), 1101 is branch (bit 5), 1110 is prefix (bit 6) and 1111 is coprocessor op (bit 7). While ins_valid is high, exactly one bit of ins_class is set.
- R4: For arithmetic and conditional-test instructions: ins_op is bits [12:8] and ins_ra is bits [7:4]. If bit 13 is 0, ins_rb is bits [3:0], ins_use_imm is 0 and ins_imm is 0. If bit 13 is 1, ins_rb is 0, ins_use_imm is 1 and ins_imm is the widened bits [3:0].
- R5: For loads and stores: ins_op is {0000, bit 12}, ins_ra (data register) is bits [11:8], ins_rb (base) is bits [7:4], ins_use_imm is 1 and ins_imm is the widened offset bits [3:0]. A coprocessor load gives ins_op = {0, bits [11:8]}, ins_ra = 0, ins_rb = bits [7:4] and the same widened offset.
- R6: A branch gives ins_imm equal to bits [11:0] sign-extended to 16 bits. A coprocessor op gives ins_imm equal to bits [11:0] zero-extended. Both set ins_use_imm to 1 and set ins_op, ins_ra and ins_rb to 0.
- R7: A prefix instruction is never presented with ins_valid high. Its slot advances after one cycle whatever the value of ins_ready.
- R8: The widened value is {pending prefix, 4-bit field} when a prefix is pending, and the 4-bit field zero-extended otherwise. The next non-prefix instruction of any class clears the pending prefix.
- R9: A second prefix before any non-prefix instruction replaces the first. A pending prefix survives the boundary between fetch words.
- R10: While ins_valid is high and ins_ready is low, all instruction outputs stay unchanged in the next cycle.
- R11: During a flush cycle fw_ready is 0. After the flush the held word is discarded (ins_valid is 0) and no prefix is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard the held word and the pending prefix |
| fw_valid | input | 1 | Fetch word offered |
| fw_data | input | 32 | Two instructions, lower half first |
| fw_ready | output | 1 | Fetch word will be taken at this edge |
| ins_valid | output | 1 | Decoded instruction present |
| ins_ready | input | 1 | Downstream takes the instruction |
| ins_class | output | 8 | One-hot class |
| ins_op | output | 5 | Operation, test or sub-field |
| ins_ra | output | 4 | Primary register index |
| ins_rb | output | 4 | Second or base register index |
| ins_use_imm | output | 1 | ins_imm is meaningful |
| ins_imm | output | 16 | Resolved immediate, offset or displacement |

## Verification
Assertions check on every cycle that the class is one-hot, that a prefix never shows as valid, that the unpacker steps from the lower to the upper slot, that a stalled instruction holds its outputs, and that the prefix register is loaded, cleared and flushed on the right edges. Only the bench's scenarios can show the decoded field values themselves and the widened immediate. The bench runs a sweep over every leading nibble against many field patterns, under both free-flowing and randomly stalled downstream. The same goes for the ordering of halves across words, prefix replacement and flush in the middle of a word.

// File: rtl/dualop_pkg.sv
package dualop_pkg;
    localparam int INSN_W  = 16;
    localparam int WORD_W  = 2 * INSN_W;
    localparam int REG_W   = 4;
    localparam int SHORT_W = 4;
    localparam int PFX_W   = 12;
    localparam int IMM_W   = PFX_W + SHORT_W;
    localparam int OP_W    = 5;
    localparam int NCLASS  = 8;

    typedef enum logic [2:0] {
        K_ALU    = 3'd0,
        K_COND   = 3'd1,
        K_LOAD   = 3'd2,
        K_STORE  = 3'd3,
        K_XLOAD  = 3'd4,
        K_BRANCH = 3'd5,
        K_PREFIX = 3'd6,
        K_XINSN  = 3'd7
    } kind_e;

    typedef struct packed {
        logic [NCLASS-1:0] cls;
        logic [OP_W-1:0]   op;
        logic [REG_W-1:0]  ra;
        logic [REG_W-1:0]  rb;
        logic              use_imm;
        logic [IMM_W-1:0]  imm;
    } dec_t;

    function automatic kind_e classify(input logic [INSN_W-1:0] x);
        kind_e k;
        if (!x[15]) begin
            k = x[14] ? K_COND : K_ALU;
        end else if (!x[14]) begin
            k = x[13] ? K_STORE : K_LOAD;
        end else begin
            unique case (x[13:12])
                2'b00:   k = K_XLOAD;
                2'b01:   k = K_BRANCH;
                2'b10:   k = K_PREFIX;
                default: k = K_XINSN;
            endcase
        end
        return k;
    endfunction
endpackage

// File: rtl/dualop_unpack.sv
module dualop_unpack
    import dualop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fw_valid,
    input  logic [WORD_W-1:0] fw_data,
    output logic              fw_ready,
    input  logic              slot_adv,
    output logic              slot_valid,
    output logic [INSN_W-1:0] slot_insn
);
    typedef enum logic [1:0] {U_EMPTY, U_LOW, U_HIGH} ustate_e;

    ustate_e           st, st_nx;
    logic [WORD_W-1:0] held;
    logic              take;

    always_comb begin
        fw_ready = !flush && ((st == U_EMPTY) || (st == U_HIGH && slot_adv));
        take     = fw_ready && fw_valid;
    end

    always_comb begin
        st_nx = st;
        if (flush) begin
            st_nx = U_EMPTY;
        end else begin
            unique case (st)
                U_EMPTY: if (take) st_nx = U_LOW;
                U_LOW:   if (slot_adv) st_nx = U_HIGH;
                U_HIGH:  if (slot_adv) st_nx = take ? U_LOW : U_EMPTY;
                default: st_nx = U_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= U_EMPTY;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    held <= '0;
        else if (take) held <= fw_data;
    end

    always_comb begin
        slot_valid = (st != U_EMPTY);
        slot_insn  = (st == U_HIGH) ? held[WORD_W-1:INSN_W] : held[INSN_W-1:0];
    end

    a_r2_no_take_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st == U_LOW) |-> !fw_ready);
    a_r2_low_then_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st == U_LOW && slot_adv && !flush) |=> (st == U_HIGH));
    a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !slot_valid);
endmodule

// File: rtl/dualop_prefix.sv
module dualop_prefix
    import dualop_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             step,
    input  logic             is_pfx,
    input  logic [PFX_W-1:0] pfx_in,
    output logic             pend,
    output logic [PFX_W-1:0] pend_val
);
    typedef enum logic {P_IDLE, P_HELD} pstate_e;

    pstate_e ps, ps_nx;

    always_comb begin
        ps_nx = ps;
        if (flush) begin
            ps_nx = P_IDLE;
        end else begin
            unique case (ps)
                P_IDLE:  if (step && is_pfx) ps_nx = P_HELD;
                P_HELD:  if (step) ps_nx = is_pfx ? P_HELD : P_IDLE;
                default: ps_nx = P_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ps <= P_IDLE;
        else        ps <= ps_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                        pend_val <= '0;
        else if (!flush && step && is_pfx) pend_val <= pfx_in;
    end

    assign pend = (ps == P_HELD);

    a_r8_consumed_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !is_pfx) |=> !pend);
    a_r9_latest_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        (step && is_pfx && !flush) |=> (pend && pend_val == $past(pfx_in)));
    a_r11_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !pend);
endmodule

// File: rtl/dualop_fields.sv
module dualop_fields
    import dualop_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    input  logic              pend,
    input  logic [PFX_W-1:0]  pend_val,
    output logic              is_pfx,
    output dec_t              dec
);
    kind_e            kind;
    logic [IMM_W-1:0] wide;

    assign kind   = classify(insn);
    assign is_pfx = (kind == K_PREFIX);
    assign wide   = {(pend ? pend_val : {PFX_W{1'b0}}), insn[SHORT_W-1:0]};

    genvar g;
    generate
        for (g = 0; g < NCLASS; g++) begin : g_onehot
            assign dec.cls[g] = (kind == kind_e'(g));
        end
    endgenerate

    always_comb begin
        dec.op      = '0;
        dec.ra      = '0;
        dec.rb      = '0;
        dec.use_imm = 1'b0;
        dec.imm     = '0;
        unique case (kind)
            K_ALU, K_COND: begin
                dec.op = insn[12:8];
                dec.ra = insn[7:4];
                if (insn[13]) begin
                    dec.use_imm = 1'b1;
                    dec.imm     = wide;
                end else begin
                    dec.rb = insn[3:0];
                end
            end
            K_LOAD, K_STORE: begin
                dec.op      = {{(OP_W-1){1'b0}}, insn[12]};
                dec.ra      = insn[11:8];
                dec.rb      = insn[7:4];
                dec.use_imm = 1'b1;
                dec.imm     = wide;
            end
            K_XLOAD: begin
                dec.op      = {1'b0, insn[11:8]};
                dec.rb      = insn[7:4];
                dec.use_imm = 1'b1;
                dec.imm     = wide;
            end
            K_BRANCH: begin
                dec.use_imm = 1'b1;
                dec.imm     = {{(IMM_W-PFX_W){insn[PFX_W-1]}}, insn[PFX_W-1:0]};
            end
            K_XINSN: begin
                dec.use_imm = 1'b1;
                dec.imm     = {{(IMM_W-PFX_W){1'b0}}, insn[PFX_W-1:0]};
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/dualop_decoder.sv
module dualop_decoder
    import dualop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fw_valid,
    input  logic [WORD_W-1:0] fw_data,
    output logic              fw_ready,
    output logic              ins_valid,
    input  logic              ins_ready,
    output logic [NCLASS-1:0] ins_class,
    output logic [OP_W-1:0]   ins_op,
    output logic [REG_W-1:0]  ins_ra,
    output logic [REG_W-1:0]  ins_rb,
    output logic              ins_use_imm,
    output logic [IMM_W-1:0]  ins_imm
);
    logic              slot_valid, slot_adv, is_pfx, pend;
    logic [INSN_W-1:0] slot_insn;
    logic [PFX_W-1:0]  pend_val;
    dec_t              dec;

    assign slot_adv = slot_valid && (is_pfx || ins_ready);

    dualop_unpack u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .fw_valid  (fw_valid),
        .fw_data   (fw_data),
        .fw_ready  (fw_ready),
        .slot_adv  (slot_adv),
        .slot_valid(slot_valid),
        .slot_insn (slot_insn)
    );

    dualop_fields u_fields (
        .insn    (slot_insn),
        .pend    (pend),
        .pend_val(pend_val),
        .is_pfx  (is_pfx),
        .dec     (dec)
    );

    dualop_prefix u_prefix (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .step    (slot_adv),
        .is_pfx  (is_pfx),
        .pfx_in  (slot_insn[PFX_W-1:0]),
        .pend    (pend),
        .pend_val(pend_val)
    );

    always_comb begin
        ins_valid   = slot_valid && !is_pfx;
        ins_class   = dec.cls;
        ins_op      = dec.op;
        ins_ra      = dec.ra;
        ins_rb      = dec.rb;
        ins_use_imm = dec.use_imm;
        ins_imm     = dec.imm;
    end

    a_r3_class_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> ($countones(ins_class) == 1));
    a_r7_prefix_never_issued: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> !ins_class[K_PREFIX]);
    a_r10_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_ready && !flush) |=>
            (ins_valid && $stable(ins_class) && $stable(ins_op) && $stable(ins_ra)
             && $stable(ins_rb) && $stable(ins_use_imm) && $stable(ins_imm)));
endmodule

// File: tb/dualop_decoder_bench.sv
`timescale 1ns/1ps
module dualop_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        fw_valid = 1'b0;
    logic [31:0] fw_data = '0;
    logic        fw_ready;
    logic        ins_valid;
    logic        ins_ready = 1'b1;
    logic [7:0]  ins_class;
    logic [4:0]  ins_op;
    logic [3:0]  ins_ra, ins_rb;
    logic        ins_use_imm;
    logic [15:0] ins_imm;

    int checks = 0;
    int fails  = 0;

    logic [15:0] q[$];
    logic        m_pv = 1'b0;
    logic [11:0] m_pval = '0;
    logic        have_word = 1'b0;
    logic [31:0] cur_word = '0;
    logic        stall_mode = 1'b0;
    logic [31:0] rnd = 32'h1F2E3D4C;
    string       imm_override = "";

    always #2.5 clk = ~clk;

    dualop_decoder u_dualop_decoder (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .fw_valid(fw_valid), .fw_data(fw_data), .fw_ready(fw_ready),
        .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_class(ins_class), .ins_op(ins_op), .ins_ra(ins_ra), .ins_rb(ins_rb),
        .ins_use_imm(ins_use_imm), .ins_imm(ins_imm)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] next_rnd(input logic [31:0] s);
        logic [31:0] v = s;
        v = v ^ (v << 13);
        v = v ^ (v >> 17);
        v = v ^ (v << 5);
        return v;
    endfunction

    task automatic model(input logic [15:0] x, input logic pv, input logic [11:0] pval,
                         output logic [7:0] cls, output logic [4:0] op,
                         output logic [3:0] ra, output logic [3:0] rb,
                         output logic ui, output logic [15:0] imm, output string tag);
        logic [15:0] wide;
        wide = {(pv ? pval : 12'h000), x[3:0]};
        cls = 0; op = 0; ra = 0; rb = 0; ui = 0; imm = 0; tag = "R4";
        if (x[15] == 1'b0) begin
            cls = x[14] ? 8'h02 : 8'h01;
            op = x[12:8]; ra = x[7:4];
            if (x[13]) begin ui = 1; imm = wide; end
            else rb = x[3:0];
        end else if (x[14] == 1'b0) begin
            cls = x[13] ? 8'h08 : 8'h04; tag = "R5";
            op = {4'b0, x[12]}; ra = x[11:8]; rb = x[7:4]; ui = 1; imm = wide;
        end else begin
            case (x[13:12])
                2'd0: begin cls = 8'h10; tag = "R5"; op = {1'b0, x[11:8]}; rb = x[7:4]; ui = 1; imm = wide; end
                2'd1: begin cls = 8'h20; tag = "R6"; ui = 1; imm = {{4{x[11]}}, x[11:0]}; end
                2'd2: begin cls = 8'h40; tag = "R7"; end
                default: begin cls = 8'h80; tag = "R6"; ui = 1; imm = {4'h0, x[11:0]}; end
            endcase
        end
    endtask

    // one cycle: drive at negedge, check, then cross the posedge
    task automatic step();
        logic [15:0] x;
        logic        xp, adv, exp_rdy, acc;
        logic [7:0]  e_cls;
        logic [4:0]  e_op;
        logic [3:0]  e_ra, e_rb;
        logic        e_ui;
        logic [15:0] e_imm;
        string       ftag, vtag, itag;
        rnd = next_rnd(rnd);
        ins_ready = stall_mode ? rnd[3] : 1'b1;
        fw_valid = have_word;
        fw_data = cur_word;
        #1;
        adv = 1'b0;
        if (q.size() > 0) begin
            x = q[0];
            xp = (x[15:12] == 4'hE);
            adv = xp || ins_ready;
            if (xp) begin
                chk(ins_valid == 1'b0, "R7 prefix slot valid", ins_valid, 0);
            end else begin
                model(x, m_pv, m_pval, e_cls, e_op, e_ra, e_rb, e_ui, e_imm, ftag);
                vtag = ins_ready ? "R2 valid" : "R10 stalled valid";
                itag = (imm_override != "") ? imm_override : (m_pv ? "R8 imm" : {ftag, " imm"});
                chk(ins_valid == 1'b1, vtag, ins_valid, 1);
                chk(ins_class == e_cls, ins_ready ? "R3 class" : "R10 class", ins_class, e_cls);
                chk(ins_op == e_op, {ftag, " op"}, ins_op, e_op);
                chk(ins_ra == e_ra, {ftag, " ra"}, ins_ra, e_ra);
                chk(ins_rb == e_rb, {ftag, " rb"}, ins_rb, e_rb);
                chk(ins_use_imm == e_ui, {ftag, " use_imm"}, ins_use_imm, e_ui);
                chk(ins_imm == e_imm, itag, ins_imm, e_imm);
            end
        end else begin
            chk(ins_valid == 1'b0, "R2 empty valid", ins_valid, 0);
        end
        exp_rdy = (q.size() == 0) || (q.size() == 1 && adv);
        chk(fw_ready == exp_rdy, "R2 fw_ready", fw_ready, exp_rdy);
        acc = fw_valid && fw_ready;
        if (adv) begin
            x = q.pop_front();
            if (x[15:12] == 4'hE) begin m_pv = 1'b1; m_pval = x[11:0]; end
            else m_pv = 1'b0;
        end
        if (acc) begin
            q.push_back(cur_word[15:0]);
            q.push_back(cur_word[31:16]);
            have_word = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send(input logic [31:0] w);
        have_word = 1'b1;
        cur_word = w;
        while (have_word) step();
        fw_valid = 1'b0;
    endtask

    task automatic drain();
        while (q.size() > 0) step();
        step();
    endtask

    task automatic do_flush();
        ins_ready = 1'b0;
        fw_valid = 1'b0;
        flush = 1'b1;
        #1;
        chk(fw_ready == 1'b0, "R11 fw_ready during flush", fw_ready, 0);
        @(posedge clk);
        @(negedge clk);
        flush = 1'b0;
        q.delete();
        m_pv = 1'b0;
        #1;
        chk(ins_valid == 1'b0, "R11 held word dropped", ins_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(fw_ready == 1'b1, "R1 fw_ready after reset", fw_ready, 1);
        chk(ins_valid == 1'b0, "R1 ins_valid after reset", ins_valid, 0);
        @(negedge clk);
        // R1: no prefix pending -> short immediate zero-extended
        imm_override = "R1 no prefix after reset";
        send({16'h0000, 16'h2A39});
        drain();
        imm_override = "";

        // R9: two prefixes in a row, the second wins; pending across words
        imm_override = "R9 replaced prefix";
        send({16'hE123, 16'hEABC});
        send({16'h0000, 16'h2057});
        drain();
        imm_override = "";

        // R11: pending prefix dropped by flush
        send({16'hE5A5, 16'h0000});
        drain();
        do_flush();
        imm_override = "R11 prefix cleared by flush";
        send({16'h0000, 16'h2057});
        drain();
        imm_override = "";

        // R11: flush with the upper half still held
        send({16'h2011, 16'h0022});
        step();
        do_flush();
        drain();

        // R3 R4 R5 R6 R8: sweep every leading nibble over many field patterns
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 256; b++) begin
                rnd = next_rnd(rnd);
                send({rnd[31:16], a[3:0], b[7:0], b[3:0] ^ 4'h5});
            end
        end
        drain();

        // R10: the same kind of stream with random downstream stalls
        stall_mode = 1'b1;
        for (int n = 0; n < 2000; n++) begin
            rnd = next_rnd(rnd);
            send(rnd);
        end
        drain();
        stall_mode = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule